// File: doc/BRIEF.md
# Software-Triggered Interrupt Generator

This block lets software raise hardware interrupt lines through a 32-bit AXI4-Lite register slave. Software writes two state words, and each of two level outputs, `irq_a` and `irq_b`, owns one select mask per state word. An output is high when its enable bit is set and at least one state bit survives its mask. A single output can be driven from either state word, and both outputs can be driven from the same word. Software clears a request by rewriting the state word or the mask, or by dropping the enable. There is no acknowledge handshake.

The control word holds the two enables. It also reports the registered level of each output, so a driver can see which line it is holding high without reading the interrupt controller. Bus bit 0 is value 0x00000001 and bus bit 31 is value 0x80000000. Each output is registered and moves one clock after the write handshake that changed its inputs.

Top module: `swirq_gen`

## Requirements
- R1: After reset every register reads 0x00000000 and both `irq_a` and `irq_b` are low.
- R2: Byte offsets decode as follows: 0x04 is state word 0 and 0x08 is state word 1. 0x0C is the A select for word 0 and 0x10 is the A select for word 1. 0x14 is the B select for word 0 and 0x18 is the B select for word 1. Each reads back the last value written and holds it until it is written again.
- R3: Control (offset 0x00) bit 0 enables `irq_a` and bit 1 enables `irq_b`, both active high and read/write.
- R4: `irq_a` is high one clock after the write that completes its inputs, exactly when bit 0 of control is 1 and ((word0 & selA0) | (word1 & selA1)) is nonzero. A select on one word has no effect on the other word.
- R5: `irq_b` follows the rule of R4 using control bit 1 and the B selects, and is independent of `irq_a`.
- R6: Control bit 28 reads the current level of `irq_a` and bit 29 reads the current level of `irq_b`. Writes to these two bits are ignored.
- R7: Control bits other than 0, 1, 28 and 29 read as zero, and so do offsets 0x1C to 0x3C. Writes to any of them change no register and no output.
- R8: Write strobe bit k updates bits 8k+7..8k of the addressed register and leaves the other lanes unchanged. The control enables sit in lane 0.
- R9: Every write and read response is OKAY (2'b00). A write response stays valid until it is accepted, and no new write is taken while it is pending. Read data stays valid and stable until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| irq_a | output | 1 | Interrupt level A |
| irq_b | output | 1 | Interrupt level B |

## Verification
On every cycle, the assertions check the following. An output can only be high if its enable was set one clock earlier, and a cleared enable forces the output low at the next edge. State words and selects hold their values whenever no write addresses them. Pending write responses and read data persist unchanged until accepted. Some behaviours can only be shown by the bench's scenarios:
- the exact decode of each offset
- the cross-word isolation of the selects
- the byte-lane merge
- the read-only level bits
- the silence of unmapped offsets

// File: rtl/swirq_pkg.sv
package swirq_pkg;
   localparam int unsigned WORD_W   = 32;
   localparam int unsigned N_WORDS  = 2;
   localparam int unsigned N_OUTS   = 2;

   // register indices (byte offset / 4)
   localparam int unsigned IDX_CTRL  = 0;
   localparam int unsigned IDX_WORD0 = 1;
   localparam int unsigned IDX_SEL0  = 3;   // sel for output o, word w at IDX_SEL0 + o*N_WORDS + w

   localparam int unsigned LVL_BIT_BASE = 28;  // level read-back of output o at bit 28+o

   localparam logic [1:0] RESP_OKAY = 2'b00;

   function automatic logic [WORD_W-1:0] lane_merge(
      input logic [WORD_W-1:0]   old_v,
      input logic [WORD_W-1:0]   new_v,
      input logic [WORD_W/8-1:0] strb);
      logic [WORD_W-1:0] r;
      r = old_v;
      for (int k = 0; k < WORD_W/8; k++) begin
         if (strb[k]) r[8*k +: 8] = new_v[8*k +: 8];
      end
      return r;
   endfunction
endpackage

// File: rtl/swirq_axil_if.sv
module swirq_axil_if #(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned DATA_W = 32,
   localparam int unsigned IDX_W  = ADDR_W - 2,
   localparam int unsigned STRB_W = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] s_awaddr,
   input  logic              s_awvalid,
   output logic              s_awready,
   input  logic [DATA_W-1:0] s_wdata,
   input  logic [STRB_W-1:0] s_wstrb,
   input  logic              s_wvalid,
   output logic              s_wready,
   output logic [1:0]        s_bresp,
   output logic              s_bvalid,
   input  logic              s_bready,
   input  logic [ADDR_W-1:0] s_araddr,
   input  logic              s_arvalid,
   output logic              s_arready,
   output logic [DATA_W-1:0] s_rdata,
   output logic [1:0]        s_rresp,
   output logic              s_rvalid,
   input  logic              s_rready,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [DATA_W-1:0] wr_data,
   output logic [STRB_W-1:0] wr_strb,
   output logic [IDX_W-1:0]  rd_idx,
   input  logic [DATA_W-1:0] rd_data
);
   import swirq_pkg::*;

   logic              bvalid_q;
   logic              rvalid_q;
   logic [DATA_W-1:0] rdata_q;
   logic              rd_fire;
   logic              unused_addr_lsb;

   assign unused_addr_lsb = ^{s_awaddr[1:0], s_araddr[1:0]};

   // a write is taken only when address and data arrive together and no response is pending
   assign wr_en     = s_awvalid && s_wvalid && !bvalid_q;
   assign s_awready = wr_en;
   assign s_wready  = wr_en;
   assign wr_idx    = s_awaddr[ADDR_W-1:2];
   assign wr_data   = s_wdata;
   assign wr_strb   = s_wstrb;

   assign s_arready = !rvalid_q;
   assign rd_fire   = s_arvalid && !rvalid_q;
   assign rd_idx    = s_araddr[ADDR_W-1:2];

   always_ff @(posedge clk) begin
      if (!rst_n)          bvalid_q <= 1'b0;
      else if (wr_en)      bvalid_q <= 1'b1;
      else if (s_bready)   bvalid_q <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rvalid_q <= 1'b0;
         rdata_q  <= '0;
      end else if (rd_fire) begin
         rvalid_q <= 1'b1;
         rdata_q  <= rd_data;
      end else if (s_rready) begin
         rvalid_q <= 1'b0;
      end
   end

   assign s_bvalid = bvalid_q;
   assign s_bresp  = RESP_OKAY;
   assign s_rvalid = rvalid_q;
   assign s_rdata  = rdata_q;
   assign s_rresp  = RESP_OKAY;

   AST_BRESP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      s_bvalid && !s_bready |=> s_bvalid); // R9
   AST_NO_WRITE_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      s_bvalid |-> !s_awready); // R9
   AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata)); // R9
endmodule

// File: rtl/swirq_regfile.sv
module swirq_regfile #(
   parameter int unsigned IDX_W  = 4,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned NW     = 2,
   parameter int unsigned NO     = 2,
   localparam int unsigned STRB_W = DATA_W / 8
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [IDX_W-1:0]                 wr_idx,
   input  logic [DATA_W-1:0]                wr_data,
   input  logic [STRB_W-1:0]                wr_strb,
   input  logic [IDX_W-1:0]                 rd_idx,
   output logic [DATA_W-1:0]                rd_data,
   input  logic [NO-1:0]                    irq_lvl,
   output logic [NO-1:0]                    en_o,
   output logic [NW-1:0][DATA_W-1:0]        word_o,
   output logic [NO-1:0][NW-1:0][DATA_W-1:0] sel_o
);
   import swirq_pkg::*;

   logic [NO-1:0]                     en_q;
   logic [NW-1:0][DATA_W-1:0]         word_q;
   logic [NO-1:0][NW-1:0][DATA_W-1:0] sel_q;

   // enables live in lane 0
   always_ff @(posedge clk) begin
      if (!rst_n) en_q <= '0;
      else if (wr_en && wr_idx == IDX_W'(IDX_CTRL) && wr_strb[0]) en_q <= wr_data[NO-1:0];
   end

   for (genvar w = 0; w < NW; w++) begin : g_word
      always_ff @(posedge clk) begin
         if (!rst_n) word_q[w] <= '0;
         else if (wr_en && wr_idx == IDX_W'(IDX_WORD0 + w))
            word_q[w] <= lane_merge(word_q[w], wr_data, wr_strb);
      end

      AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         !(wr_en && wr_idx == IDX_W'(IDX_WORD0 + w)) |=> $stable(word_q[w])); // R2
   end

   for (genvar o = 0; o < NO; o++) begin : g_out
      for (genvar w = 0; w < NW; w++) begin : g_sel
         always_ff @(posedge clk) begin
            if (!rst_n) sel_q[o][w] <= '0;
            else if (wr_en && wr_idx == IDX_W'(IDX_SEL0 + o*NW + w))
               sel_q[o][w] <= lane_merge(sel_q[o][w], wr_data, wr_strb);
         end

         AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_idx == IDX_W'(IDX_SEL0 + o*NW + w)) |=> $stable(sel_q[o][w])); // R2
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_idx == IDX_W'(IDX_CTRL)) begin
         rd_data[NO-1:0]               = en_q;
         rd_data[LVL_BIT_BASE +: NO]   = irq_lvl;
      end
      for (int w = 0; w < NW; w++) begin
         if (rd_idx == IDX_W'(IDX_WORD0 + w)) rd_data = word_q[w];
      end
      for (int o = 0; o < NO; o++) begin
         for (int w = 0; w < NW; w++) begin
            if (rd_idx == IDX_W'(IDX_SEL0 + o*NW + w)) rd_data = sel_q[o][w];
         end
      end
   end

   assign en_o   = en_q;
   assign word_o = word_q;
   assign sel_o  = sel_q;
endmodule

// File: rtl/swirq_combine.sv
module swirq_combine #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned NW     = 2,
   parameter int unsigned NO     = 2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [NO-1:0]                     en_i,
   input  logic [NW-1:0][DATA_W-1:0]         word_i,
   input  logic [NO-1:0][NW-1:0][DATA_W-1:0] sel_i,
   output logic [NO-1:0]                     irq_o
);
   logic [NO-1:0] hit;
   logic [NO-1:0] irq_q;

   always_comb begin
      hit = '0;
      for (int o = 0; o < NO; o++) begin
         for (int w = 0; w < NW; w++) begin
            hit[o] = hit[o] | (|(word_i[w] & sel_i[o][w]));
         end
      end
   end

   for (genvar o = 0; o < NO; o++) begin : g_lvl
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q[o] <= 1'b0;
         else        irq_q[o] <= en_i[o] & hit[o];
      end

      AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
         irq_q[o] |-> $past(en_i[o])); // R4
      AST_IRQ_DROPS_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
         !en_i[o] |=> !irq_q[o]); // R5
   end

   assign irq_o = irq_q;
endmodule

// File: rtl/swirq_gen.sv
module swirq_gen #(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned DATA_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     s_awaddr,
   input  logic                  s_awvalid,
   output logic                  s_awready,
   input  logic [DATA_W-1:0]     s_wdata,
   input  logic [DATA_W/8-1:0]   s_wstrb,
   input  logic                  s_wvalid,
   output logic                  s_wready,
   output logic [1:0]            s_bresp,
   output logic                  s_bvalid,
   input  logic                  s_bready,
   input  logic [ADDR_W-1:0]     s_araddr,
   input  logic                  s_arvalid,
   output logic                  s_arready,
   output logic [DATA_W-1:0]     s_rdata,
   output logic [1:0]            s_rresp,
   output logic                  s_rvalid,
   input  logic                  s_rready,
   output logic                  irq_a,
   output logic                  irq_b
);
   import swirq_pkg::*;

   localparam int unsigned IDX_W  = ADDR_W - 2;
   localparam int unsigned STRB_W = DATA_W / 8;

   if (DATA_W != WORD_W) begin : g_bad_width
      $error("swirq_gen: DATA_W must be 32");
   end
   if (ADDR_W < 5 || ADDR_W > 16) begin : g_bad_addr
      $error("swirq_gen: ADDR_W must be 5..16");
   end

   logic                                  wr_en;
   logic [IDX_W-1:0]                      wr_idx;
   logic [DATA_W-1:0]                     wr_data;
   logic [STRB_W-1:0]                     wr_strb;
   logic [IDX_W-1:0]                      rd_idx;
   logic [DATA_W-1:0]                     rd_data;
   logic [N_OUTS-1:0]                     en;
   logic [N_OUTS-1:0]                     irq;
   logic [N_WORDS-1:0][DATA_W-1:0]        word;
   logic [N_OUTS-1:0][N_WORDS-1:0][DATA_W-1:0] sel;

   swirq_axil_if #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
      .clk(clk), .rst_n(rst_n),
      .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
      .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
      .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
      .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
      .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_strb(wr_strb),
      .rd_idx(rd_idx), .rd_data(rd_data)
   );

   swirq_regfile #(.IDX_W(IDX_W), .DATA_W(DATA_W), .NW(N_WORDS), .NO(N_OUTS)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_strb(wr_strb),
      .rd_idx(rd_idx), .rd_data(rd_data), .irq_lvl(irq),
      .en_o(en), .word_o(word), .sel_o(sel)
   );

   swirq_combine #(.DATA_W(DATA_W), .NW(N_WORDS), .NO(N_OUTS)) u_comb (
      .clk(clk), .rst_n(rst_n),
      .en_i(en), .word_i(word), .sel_i(sel), .irq_o(irq)
   );

   assign irq_a = irq[0];
   assign irq_b = irq[1];
endmodule

// File: tb/tb_swirq_gen.sv
module tb_swirq_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  s_awaddr = '0;
   logic        s_awvalid = 1'b0;
   logic        s_awready;
   logic [31:0] s_wdata = '0;
   logic [3:0]  s_wstrb = '0;
   logic        s_wvalid = 1'b0;
   logic        s_wready;
   logic [1:0]  s_bresp;
   logic        s_bvalid;
   logic        s_bready = 1'b1;
   logic [5:0]  s_araddr = '0;
   logic        s_arvalid = 1'b0;
   logic        s_arready;
   logic [31:0] s_rdata;
   logic [1:0]  s_rresp;
   logic        s_rvalid;
   logic        s_rready = 1'b1;
   logic        irq_a;
   logic        irq_b;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   swirq_gen dut (.*);

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(logic [5:0] a, logic [31:0] d, logic [3:0] st = 4'hF);
      @(negedge clk);
      s_awaddr = a; s_wdata = d; s_wstrb = st; s_awvalid = 1'b1; s_wvalid = 1'b1;
      #1;
      while (!s_awready) begin @(negedge clk); #1; end
      @(posedge clk); #1;
      s_awvalid = 1'b0; s_wvalid = 1'b0;
      check("R9 bresp", {29'd0, s_bvalid, s_bresp}, 32'h4);
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic rd(logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      s_araddr = a; s_arvalid = 1'b1;
      #1;
      while (!s_arready) begin @(negedge clk); #1; end
      @(posedge clk); #1;
      s_arvalid = 1'b0;
      d = s_rdata;
      check("R9 rresp", {29'd0, s_rvalid, s_rresp}, 32'h4);
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic rd_chk(string req, logic [5:0] a, logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      check(req, v, exp);
   endtask

   task automatic clear_all();
      for (int i = 0; i < 7; i++) wr(6'(4*i), 32'h0);
   endtask

   task automatic t_reset();
      check("R1 irq_a", {31'd0, irq_a}, 32'h0);
      check("R1 irq_b", {31'd0, irq_b}, 32'h0);
      for (int i = 0; i < 7; i++) rd_chk("R1 reg", 6'(4*i), 32'h0);
   endtask

   task automatic t_map();
      wr(6'h04, 32'h1111_0001); wr(6'h08, 32'h2222_0002);
      wr(6'h0C, 32'h3333_0004); wr(6'h10, 32'h4444_0008);
      wr(6'h14, 32'h5555_0010); wr(6'h18, 32'h6666_0020);
      rd_chk("R2 word0", 6'h04, 32'h1111_0001);
      rd_chk("R2 word1", 6'h08, 32'h2222_0002);
      rd_chk("R2 selA0", 6'h0C, 32'h3333_0004);
      rd_chk("R2 selA1", 6'h10, 32'h4444_0008);
      rd_chk("R2 selB0", 6'h14, 32'h5555_0010);
      rd_chk("R2 selB1", 6'h18, 32'h6666_0020);
      check("R3 enables off, irq_a", {31'd0, irq_a}, 32'h0);
      wr(6'h00, 32'hFFFF_FFFF);
      rd_chk("R3 R6 R7 ctrl all-ones write", 6'h00, 32'h3000_0003);
      clear_all();
   endtask

   task automatic t_irq_a();
      wr(6'h04, 32'h0000_0100); wr(6'h0C, 32'h0000_0100);
      check("R4 gated by enable", {31'd0, irq_a}, 32'h0);
      wr(6'h00, 32'h1);
      check("R4 irq_a via word0", {31'd0, irq_a}, 32'h1);
      check("R5 irq_b untouched", {31'd0, irq_b}, 32'h0);
      rd_chk("R6 level A read-back", 6'h00, 32'h1000_0001);
      wr(6'h04, 32'h0);
      check("R4 irq_a cleared by word", {31'd0, irq_a}, 32'h0);
      wr(6'h10, 32'h0000_0020); wr(6'h04, 32'h0000_0020);
      check("R4 selA1 ignores word0", {31'd0, irq_a}, 32'h0);
      wr(6'h08, 32'h8000_0020);
      check("R4 irq_a via word1", {31'd0, irq_a}, 32'h1);
      wr(6'h00, 32'h0);
      check("R4 irq_a disabled", {31'd0, irq_a}, 32'h0);
      clear_all();
   endtask

   task automatic t_irq_b();
      wr(6'h18, 32'h0001_0000); wr(6'h08, 32'h0001_0000); wr(6'h00, 32'h2);
      check("R5 irq_b via word1", {31'd0, irq_b}, 32'h1);
      check("R4 irq_a untouched", {31'd0, irq_a}, 32'h0);
      wr(6'h14, 32'h4); wr(6'h04, 32'h4); wr(6'h08, 32'h0);
      check("R5 irq_b via word0", {31'd0, irq_b}, 32'h1);
      wr(6'h0C, 32'h4); wr(6'h00, 32'h3);
      check("R4 both from word0", {30'd0, irq_b, irq_a}, 32'h3);
      rd_chk("R6 both levels", 6'h00, 32'h3000_0003);
      wr(6'h04, 32'h0);
      check("R5 both cleared", {30'd0, irq_b, irq_a}, 32'h0);
      rd_chk("R6 levels low", 6'h00, 32'h0000_0003);
      clear_all();
   endtask

   task automatic t_ro_bits();
      wr(6'h00, 32'h3000_0000);
      rd_chk("R6 level bits not writable", 6'h00, 32'h0);
      check("R6 no irq from write", {30'd0, irq_b, irq_a}, 32'h0);
      wr(6'h04, 32'h1); wr(6'h0C, 32'h1); wr(6'h00, 32'h1);
      wr(6'h00, 32'h2000_0001);
      rd_chk("R6 bit29 write ignored", 6'h00, 32'h1000_0001);
      check("R6 irq_b stays low", {31'd0, irq_b}, 32'h0);
      clear_all();
   endtask

   task automatic t_unmapped();
      wr(6'h04, 32'hCAFE_F00D);
      wr(6'h1C, 32'hFFFF_FFFF); wr(6'h3C, 32'hFFFF_FFFF); wr(6'h20, 32'hFFFF_FFFF);
      rd_chk("R7 0x1C reads zero", 6'h1C, 32'h0);
      rd_chk("R7 0x3C reads zero", 6'h3C, 32'h0);
      rd_chk("R7 word0 untouched", 6'h04, 32'hCAFE_F00D);
      rd_chk("R7 ctrl untouched", 6'h00, 32'h0);
      rd_chk("R7 selA0 untouched", 6'h0C, 32'h0);
      check("R7 no irq", {30'd0, irq_b, irq_a}, 32'h0);
      clear_all();
   endtask

   task automatic t_strobe();
      wr(6'h08, 32'hAABB_CCDD, 4'b0101);
      rd_chk("R8 lanes 0,2", 6'h08, 32'h00BB_00DD);
      wr(6'h08, 32'h1122_3344, 4'b1000);
      rd_chk("R8 lane 3", 6'h08, 32'h11BB_00DD);
      wr(6'h00, 32'h0000_0003, 4'b0010);
      rd_chk("R8 ctrl lane0 unselected", 6'h00, 32'h0);
      wr(6'h00, 32'h0000_0003, 4'b0001);
      rd_chk("R8 ctrl lane0 selected", 6'h00, 32'h3);
      clear_all();
   endtask

   task automatic t_hold();
      logic [31:0] v;
      s_bready = 1'b0;
      @(negedge clk);
      s_awaddr = 6'h04; s_wdata = 32'h0000_0055; s_wstrb = 4'hF; s_awvalid = 1'b1; s_wvalid = 1'b1;
      #1;
      while (!s_awready) begin @(negedge clk); #1; end
      @(posedge clk); #1;
      s_awvalid = 1'b0; s_wvalid = 1'b0;
      repeat (3) @(negedge clk);
      check("R9 bvalid held", {31'd0, s_bvalid}, 32'h1);
      s_awaddr = 6'h08; s_wdata = 32'h0000_0077; s_awvalid = 1'b1; s_wvalid = 1'b1;
      #1;
      check("R9 no accept while pending", {31'd0, s_awready}, 32'h0);
      @(negedge clk);
      s_awvalid = 1'b0; s_wvalid = 1'b0;
      s_bready = 1'b1;
      @(negedge clk);
      check("R9 bvalid released", {31'd0, s_bvalid}, 32'h0);
      rd_chk("R9 blocked write dropped", 6'h08, 32'h0);
      s_rready = 1'b0;
      @(negedge clk);
      s_araddr = 6'h04; s_arvalid = 1'b1;
      @(posedge clk); #1;
      s_arvalid = 1'b0;
      repeat (3) @(negedge clk);
      check("R9 rvalid held", {31'd0, s_rvalid}, 32'h1);
      check("R9 rdata held", s_rdata, 32'h0000_0055);
      s_rready = 1'b1;
      @(negedge clk);
      check("R9 rvalid released", {31'd0, s_rvalid}, 32'h0);
      rd(6'h04, v);
      check("R2 pending write landed", v, 32'h0000_0055);
      clear_all();
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_map();
      t_irq_a();
      t_irq_b();
      t_ro_bits();
      t_unmapped();
      t_strobe();
      t_hold();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule